// File: doc/BRIEF.md
# Load-Miss Gain History Table

This block belongs to one thread of a memory scheduler. It learns which load program counters tend to hold up progress when they miss in the last-level cache. Each time a new miss is reported, the block searches a fully associative table for the miss PC. It answers with a hit flag and a small saturating reference count, which the scheduler uses as an instruction-level priority. Scheduling the requests is left to the scheduler.

The block also keeps the PC of the most recent miss and a gain counter. The counter advances on every DRAM-cycle tick until the next miss arrives. At that miss, the held record is committed to the table. If the measured gap is larger than a threshold, a table hit is incremented and a table miss allocates a new entry. If the gap is at or below the threshold, a table hit is decremented by a configurable step and a table miss leaves the table unchanged. The register then takes the new PC and its gain restarts from zero.

Top module: `gain_hist_table`

## Requirements
- R1: After reset, hit_o, ref_cnt_o and lookup_valid_o are 0 and every table entry is invalid.
- R2: lookup_valid_o is high for exactly the cycle after each cycle in which miss_valid_i is high. hit_o and ref_cnt_o are registered with it and hold their values until the next miss.
- R3: A lookup whose PC matches a valid entry returns hit_o=1 and that entry's count. Otherwise it returns hit_o=0 and ref_cnt_o=0.
- R4: Once a miss has loaded the last-miss record, its gain advances by one for each tick_i cycle without a miss and saturates at 2^GAIN_W-1. A miss clears the gain to 0, and a tick in the same cycle as a miss is not counted.
- R5: At a commit with gain > GAIN_TH and the held PC absent from the table, a new entry is written with count 0. It goes into the lowest-indexed invalid slot.
- R6: At a commit with gain > GAIN_TH and the held PC present, that entry's count increases by 1 and saturates at 127.
- R7: At a commit with gain <= GAIN_TH, a present entry's count drops by DEC_STEP, floored at 0. An absent PC allocates nothing.
- R8: When all slots are valid, an allocation replaces the slot chosen by a round-robin pointer. The pointer starts at slot 0 and advances by one, wrapping, after each such replacement.
- R9: The lookup for a miss sees the table as it stood before that same miss's commit.
- R10: The first miss after reset commits nothing, because no record is held yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One DRAM-cycle tick |
| miss_valid_i | input | 1 | New last-level-cache load miss |
| miss_pc_i | input | 32 | PC of the missing load |
| lookup_valid_o | output | 1 | Lookup result valid, one cycle after the miss |
| hit_o | output | 1 | PC found in the table |
| ref_cnt_o | output | 7 | Reference count of the matching entry, or 0 |

## Verification
Each lookup result appears one clock after the cycle in which miss_valid_i is high. The bench drives the miss on a falling edge and reads lookup_valid_o, hit_o and ref_cnt_o at the next falling edge. A commit changes the table at that same rising edge. Its effect therefore shows only in the result of a later miss, and the bench's model applies each commit only after comparing the lookup taken before it. Gain counting is observed at the ports by choosing tick gaps just below, at and above the threshold, and beyond the counter width.

// File: rtl/ght_pkg.sv
package ght_pkg;
  localparam int PC_W  = 32;
  localparam int CNT_W = 7;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_INC   = 2'd2,
    ACT_DEC   = 2'd3
  } act_e;
endpackage

// File: rtl/ght_cam.sv
module ght_cam #(
  parameter int ENTRIES = 512,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]                   vld_i,
  input  logic [ENTRIES-1:0][ght_pkg::PC_W-1:0] tag_i,
  input  logic [ght_pkg::PC_W-1:0]             key_i,
  output logic                                 hit_o,
  output logic [IW-1:0]                        idx_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_i[g] && (tag_i[g] == key_i);
  end

  // lowest matching index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/ght_victim.sv
module ght_victim #(
  parameter int ENTRIES = 512,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] vld_i,
  input  logic               take_i,
  output logic [IW-1:0]      idx_o
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [IW-1:0] free_idx, rr_q;
  logic          full;

  assign full = &vld_i;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_i[i]) free_idx = i[IW-1:0];
    end
  end

  assign idx_o = full ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rr_q <= '0;
    else if (take_i && full) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/ght_last_miss.sv
module ght_last_miss #(
  parameter int GAIN_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     load_i,
  input  logic [ght_pkg::PC_W-1:0] pc_i,
  output logic                     vld_o,
  output logic [ght_pkg::PC_W-1:0] pc_o,
  output logic [GAIN_W-1:0]        gain_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      pc_o   <= '0;
      gain_o <= '0;
    end else if (load_i) begin
      vld_o  <= 1'b1;
      pc_o   <= pc_i;
      gain_o <= '0;
    end else if (vld_o && tick_i && (gain_o != '1)) begin
      gain_o <= gain_o + 1'b1;
    end
  end
endmodule

// File: rtl/gain_hist_table.sv
module gain_hist_table #(
  parameter int ENTRIES  = 512,
  parameter int GAIN_W   = 32,
  parameter int GAIN_TH  = 64,
  parameter int DEC_STEP = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        miss_valid_i,
  input  logic [31:0] miss_pc_i,
  output logic        lookup_valid_o,
  output logic        hit_o,
  output logic [6:0]  ref_cnt_o
);
  import ght_pkg::*;

  localparam int IW = $clog2(ENTRIES);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [CNT_W-1:0]  DEC_V   = CNT_W'(DEC_STEP);
  localparam logic [GAIN_W-1:0] TH_V    = GAIN_W'(GAIN_TH);

  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][PC_W-1:0]  tag_q;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_q;

  logic              lm_vld;
  logic [PC_W-1:0]   lm_pc;
  logic [GAIN_W-1:0] lm_gain;

  logic          l_hit, c_hit;
  logic [IW-1:0] l_idx, c_idx, v_idx;
  act_e          act;

  ght_cam #(.ENTRIES(ENTRIES)) u_cam_lookup (
    .vld_i(vld_q), .tag_i(tag_q), .key_i(miss_pc_i),
    .hit_o(l_hit), .idx_o(l_idx)
  );

  ght_cam #(.ENTRIES(ENTRIES)) u_cam_commit (
    .vld_i(vld_q), .tag_i(tag_q), .key_i(lm_pc),
    .hit_o(c_hit), .idx_o(c_idx)
  );

  ght_last_miss #(.GAIN_W(GAIN_W)) u_last (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .load_i(miss_valid_i), .pc_i(miss_pc_i),
    .vld_o(lm_vld), .pc_o(lm_pc), .gain_o(lm_gain)
  );

  ght_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_q),
    .take_i(act == ACT_ALLOC), .idx_o(v_idx)
  );

  always_comb begin
    act = ACT_NONE;
    if (miss_valid_i && lm_vld) begin
      if (lm_gain > TH_V) act = c_hit ? ACT_INC : ACT_ALLOC;
      else if (c_hit)     act = ACT_DEC;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (act)
        ACT_ALLOC: begin
          vld_q[v_idx] <= 1'b1;
          tag_q[v_idx] <= lm_pc;
          cnt_q[v_idx] <= '0;
        end
        ACT_INC: if (cnt_q[c_idx] != CNT_MAX) cnt_q[c_idx] <= cnt_q[c_idx] + 1'b1;
        ACT_DEC: cnt_q[c_idx] <= (cnt_q[c_idx] > DEC_V) ? cnt_q[c_idx] - DEC_V : '0;
        default: ;
      endcase
    end
  end

  // result reflects table contents before this miss's commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lookup_valid_o <= 1'b0;
      hit_o          <= 1'b0;
      ref_cnt_o      <= '0;
    end else begin
      lookup_valid_o <= miss_valid_i;
      if (miss_valid_i) begin
        hit_o     <= l_hit;
        ref_cnt_o <= l_hit ? cnt_q[l_idx] : '0;
      end
    end
  end
endmodule

// File: rtl/ght_chk.sv
module ght_chk #(
  parameter int GAIN_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              miss_valid_i,
  input logic [31:0]       miss_pc_i,
  input logic              lookup_valid_o,
  input logic              hit_o,
  input logic [6:0]        ref_cnt_o,
  input logic              lm_vld,
  input logic [31:0]       lm_pc,
  input logic [GAIN_W-1:0] lm_gain
);
  assert_lookup_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> lookup_valid_o);
  assert_lookup_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> !lookup_valid_o);
  assert_result_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> ($stable(hit_o) && $stable(ref_cnt_o)));
  assert_miss_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ref_cnt_o == 7'd0));
  assert_gain_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> (lm_vld && lm_gain == '0 && lm_pc == $past(miss_pc_i)));
  assert_gain_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_valid_i && tick_i && lm_vld && lm_gain != '1)
      |=> (lm_gain == GAIN_W'($past(lm_gain) + 1'b1)));
  assert_gain_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_valid_i && lm_gain == '1) |=> (lm_gain == '1));
endmodule

bind gain_hist_table ght_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .miss_valid_i(miss_valid_i), .miss_pc_i(miss_pc_i),
  .lookup_valid_o(lookup_valid_o), .hit_o(hit_o), .ref_cnt_o(ref_cnt_o),
  .lm_vld(lm_vld), .lm_pc(lm_pc), .lm_gain(lm_gain)
);

// File: tb/gain_hist_table_tb.sv
`timescale 1ns/1ps
module gain_hist_table_tb;
  localparam int N    = 4;
  localparam int GW   = 3;
  localparam int TH   = 3;
  localparam int DEC  = 2;
  localparam int GMAX = (1 << GW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        miss = 1'b0;
  logic [31:0] pc = '0;
  logic        lkv, hit;
  logic [6:0]  refc;

  int n_run = 0;
  int n_fail = 0;

  // bench-side expectation state
  bit          m_vld[N];
  logic [31:0] m_tag[N];
  int          m_cnt[N];
  int          m_rr = 0;
  bit          m_lv = 0;
  logic [31:0] m_lpc = '0;

  always #2 clk = ~clk;

  gain_hist_table #(.ENTRIES(N), .GAIN_W(GW), .GAIN_TH(TH), .DEC_STEP(DEC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .miss_valid_i(miss),
    .miss_pc_i(pc), .lookup_valid_o(lkv), .hit_o(hit), .ref_cnt_o(refc)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find(input logic [31:0] p);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == p) return i;
    return -1;
  endfunction

  function automatic void model_commit(input int gap);
    int g, i, v;
    if (!m_lv) return;
    g = (gap > GMAX) ? GMAX : gap;
    i = find(m_lpc);
    if (g > TH) begin
      if (i >= 0) begin
        if (m_cnt[i] < 127) m_cnt[i]++;
      end else begin
        v = -1;
        for (int k = N - 1; k >= 0; k--) if (!m_vld[k]) v = k;
        if (v < 0) begin
          v = m_rr;
          m_rr = (m_rr + 1) % N;
        end
        m_vld[v] = 1; m_tag[v] = m_lpc; m_cnt[v] = 0;
      end
    end else if (i >= 0) begin
      m_cnt[i] = (m_cnt[i] > DEC) ? m_cnt[i] - DEC : 0;
    end
  endfunction

  task automatic do_miss(input logic [31:0] p, input int gap, input bit tick_too, input string req);
    int i, e_cnt;
    bit e_hit;
    for (int t = 0; t < gap; t++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk);
    tick = tick_too; miss = 1'b1; pc = p;
    i = find(p);
    e_hit = (i >= 0);
    e_cnt = e_hit ? m_cnt[i] : 0;
    model_commit(gap);
    m_lv = 1; m_lpc = p;
    @(negedge clk);
    miss = 1'b0; tick = 1'b0;
    check("R2", "lookup_valid", int'(lkv), 1);
    check(req, "hit", int'(hit), int'(e_hit));
    check(req, "ref_cnt", int'(refc), e_cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "hit in reset", int'(hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "hit", int'(hit), 0);
    check("R1", "ref_cnt", int'(refc), 0);
    check("R1", "lookup_valid", int'(lkv), 0);

    do_miss(32'h100, 6, 0, "R10");     // nothing to commit
    do_miss(32'h200, 5, 0, "R5");      // 0x100 allocated, slot 0
    do_miss(32'h100, 5, 0, "R5");      // hit with count 0
    do_miss(32'h100, 5, 0, "R9");      // still 0, pre-commit view
    do_miss(32'h100, 5, 0, "R6");      // now 1

    repeat (3) @(negedge clk);
    check("R2", "idle lookup_valid", int'(lkv), 0);
    check("R2", "held hit", int'(hit), 1);
    check("R2", "held ref_cnt", int'(refc), 1);

    for (int k = 0; k < 130; k++) do_miss(32'h100, 4, 0, "R6");   // saturate at 127
    for (int k = 0; k < 70; k++)  do_miss(32'h100, 1, 0, "R7");   // floor at 0

    do_miss(32'h300, 5, 0, "R4");      // 0x100 hit, incremented
    do_miss(32'h400, 3, 1, "R4");      // 0x300 gap 3: not allocated; tick with miss
    do_miss(32'h500, 3, 0, "R4");      // 0x400 gap 3 (tick not counted): not allocated
    do_miss(32'h300, 1, 0, "R7");
    do_miss(32'h400, 1, 0, "R7");
    do_miss(32'h600, 9, 0, "R4");      // saturated gain allocates 0x400
    do_miss(32'h400, 4, 0, "R4");      // 0x600 at TH+1 allocated

    // fill and replace round-robin
    for (int k = 0; k < 6; k++) do_miss(32'h1000 + 32'(k * 16), 5, 0, "R8");
    for (int k = 0; k < 6; k++) do_miss(32'h1000 + 32'(k * 16), 2, 0, "R8");
    foreach (m_tag[k]) do_miss(m_tag[k], 0, 0, "R3");
    do_miss(32'h100, 2, 0, "R3");
    do_miss(32'h200, 2, 0, "R3");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule